// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block runs a full-duplex, byte-at-a-time message link in which every frame carries one data byte, a message-active flag and an acknowledge bit in each direction. On the receive side a byte counts only once two flagged frames in a row have carried the same value. The block then places the byte in a host-visible register and acknowledges it. If the host has not yet taken the previous byte, the acknowledge is held back, and this throttles the remote sender. If the two copies differ, the message is aborted towards the sender.

On the transmit side the host writes bytes into a single holding register. Each byte is moved onto the line and repeated there until the far end acknowledges it, and an idle frame is inserted between bytes. A message closes when the host marks a byte as last or when no further byte is waiting. A second acknowledge arriving in the idle frame is taken as an abort from the far end. The host sees one-cycle interrupt pulses for receive-ready, receive-abort, end-of-message and transmit-abort, and a level for transmit-ready.

Top module: `monitor_link`

## Requirements
- R1: The sampling cycle is the one where `frame_tick` is high. When a flagged frame's byte equals the byte of the flagged frame just before it, and the receive register is free, that byte appears on `rd_data` and `irq_rx_ready` pulses for one cycle.
- R2: Bytes of a message are delivered in the order sent. This includes equal consecutive bytes, which are kept apart by at least one unflagged frame.
- R3: Every delivered byte is answered with `tx_ack` high for exactly one frame (frame_tick period), starting right after the delivering tick.
- R4: When the second copy differs from the first, `irq_rx_abort` pulses and `tx_ack` is high for exactly two frames. The byte is discarded, and the rest of that message produces no end-of-message.
- R5: While the receive register is still full, a matched byte is neither acknowledged nor delivered. It is delivered and acknowledged at the first tick at which the register is free. A `host_rd` in the tick cycle itself counts as freeing it.
- R6: `irq_eom` pulses when two consecutive unflagged frames follow an open message.
- R7: A byte written while the transmitter is idle goes onto the line at the next tick with `tx_flag` high. It stays there until an acknowledge is sampled.
- R8: `irq_tx_ready` is high exactly when the holding register is empty. A write while it is high makes it low from the next cycle. A write while it is low is ignored.
- R9: After an acknowledge, one unflagged frame follows. If that byte was written with `host_last`, or no byte is waiting, the message ends with a second unflagged frame, so the far end sees end of message.
- R10: An acknowledge sampled in the idle frame just after an acknowledge is an abort. `irq_tx_abort` pulses, any waiting byte is dropped and the transmitter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | High for one cycle per frame; line fields are sampled and updated there |
| rx_byte | input | W | Incoming data byte of the current frame |
| rx_flag | input | 1 | Incoming message-active flag |
| rx_ack | input | 1 | Incoming acknowledge for bytes this block sends |
| tx_byte | output | W | Outgoing data byte |
| tx_flag | output | 1 | Outgoing message-active flag |
| tx_ack | output | 1 | Outgoing acknowledge for bytes this block receives |
| host_rd | input | 1 | Host consumes the receive register |
| rd_data | output | W | Receive register |
| host_wr | input | 1 | Host writes the holding register |
| host_last | input | 1 | Marks the written byte as the last of its message |
| wr_data | input | W | Byte written by the host |
| irq_rx_ready | output | 1 | Pulse: new byte in `rd_data` |
| irq_rx_abort | output | 1 | Pulse: repetition mismatch, abort sent |
| irq_eom | output | 1 | Pulse: end of message received |
| irq_tx_ready | output | 1 | Level: holding register empty |
| irq_tx_abort | output | 1 | Pulse: abort received from far end |

## Verification
Two things can happen in one cycle: the host's read of the receive register and the frame tick that would deliver a byte held back behind it. A slow-host run leaves one byte unread while the next one is matched and parked. The bench then raises `host_rd` exactly in a tick cycle. It checks that the parked byte is delivered and acknowledged at that same edge, and that no acknowledge appeared while the register was full.

// File: rtl/monitor_link.sv
module monitor_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_tick,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_flag,
  input  logic         rx_ack,
  output logic [W-1:0] tx_byte,
  output logic         tx_flag,
  output logic         tx_ack,
  input  logic         host_rd,
  output logic [W-1:0] rd_data,
  input  logic         host_wr,
  input  logic         host_last,
  input  logic [W-1:0] wr_data,
  output logic         irq_rx_ready,
  output logic         irq_rx_abort,
  output logic         irq_eom,
  output logic         irq_tx_ready,
  output logic         irq_tx_abort
);
  typedef enum logic [1:0] {R_FIRST, R_SECOND, R_HELD, R_DROP} rx_st_e;
  typedef enum logic [1:0] {T_IDLE, T_SEND, T_GAP, T_END} tx_st_e;

  rx_st_e       rs;
  logic [W-1:0] cand, rd_q;
  logic         rx_full, pend, in_msg, idle1;
  logic [1:0]   ack_cnt;
  wire          space = !rx_full || host_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs <= R_FIRST; cand <= '0; rd_q <= '0; rx_full <= 1'b0; pend <= 1'b0;
      in_msg <= 1'b0; idle1 <= 1'b0; ack_cnt <= '0;
      irq_rx_ready <= 1'b0; irq_rx_abort <= 1'b0; irq_eom <= 1'b0;
    end else begin
      irq_rx_ready <= 1'b0;
      irq_rx_abort <= 1'b0;
      irq_eom      <= 1'b0;
      if (host_rd) rx_full <= 1'b0;
      if (frame_tick) begin
        ack_cnt <= (ack_cnt != 0) ? ack_cnt - 2'd1 : 2'd0;
        if (rx_flag) begin
          idle1 <= 1'b0;
          case (rs)
            R_FIRST: begin
              cand <= rx_byte; rs <= R_SECOND; in_msg <= 1'b1;
            end
            R_SECOND: begin
              if (rx_byte == cand) begin
                rs <= R_HELD;
                if (space) begin
                  rd_q <= cand; rx_full <= 1'b1; irq_rx_ready <= 1'b1; ack_cnt <= 2'd1;
                end else begin
                  pend <= 1'b1;
                end
              end else begin
                rs <= R_DROP; in_msg <= 1'b0; irq_rx_abort <= 1'b1; ack_cnt <= 2'd2;
              end
            end
            R_HELD: begin
              if (pend && space) begin
                rd_q <= cand; rx_full <= 1'b1; irq_rx_ready <= 1'b1; ack_cnt <= 2'd1;
                pend <= 1'b0;
              end
            end
            default: ;
          endcase
        end else begin
          rs    <= R_FIRST;
          pend  <= 1'b0;
          idle1 <= 1'b1;
          if (in_msg && idle1) begin
            irq_eom <= 1'b1; in_msg <= 1'b0;
          end
        end
      end
    end
  end

  assign tx_ack  = ack_cnt != 0;
  assign rd_data = rd_q;

  tx_st_e       ts;
  logic [W-1:0] hold_q, line_q;
  logic         hold_full, hold_last, line_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts <= T_IDLE; hold_q <= '0; line_q <= '0;
      hold_full <= 1'b0; hold_last <= 1'b0; line_last <= 1'b0;
      irq_tx_abort <= 1'b0;
    end else begin
      irq_tx_abort <= 1'b0;
      if (host_wr && !hold_full) begin
        hold_q <= wr_data; hold_last <= host_last; hold_full <= 1'b1;
      end
      if (frame_tick) begin
        case (ts)
          T_IDLE: if (hold_full) begin
            line_q <= hold_q; line_last <= hold_last; hold_full <= 1'b0; ts <= T_SEND;
          end
          T_SEND: if (rx_ack) ts <= T_GAP;
          T_GAP: begin
            if (rx_ack) begin
              irq_tx_abort <= 1'b1; hold_full <= 1'b0; ts <= T_IDLE;
            end else if (!line_last && hold_full) begin
              line_q <= hold_q; line_last <= hold_last; hold_full <= 1'b0; ts <= T_SEND;
            end else begin
              ts <= T_END;
            end
          end
          default: ts <= T_IDLE;
        endcase
      end
    end
  end

  assign tx_byte      = line_q;
  assign tx_flag      = ts == T_SEND;
  assign irq_tx_ready = !hold_full;
endmodule

module monitor_link_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic rx_ack,
  input logic rx_flag,
  input logic rx_full,
  input logic tx_ack,
  input logic tx_flag,
  input logic irq_rx_ready,
  input logic irq_rx_abort,
  input logic irq_eom,
  input logic irq_tx_ready,
  input logic irq_tx_abort
);
  p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_ready |-> rx_full);
  p_ready_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_ready |-> tx_ack);
  p_abort_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_abort |-> (tx_ack && !irq_rx_ready));
  p_eom_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eom |-> !$past(rx_flag));
  p_write_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && irq_tx_ready && !rx_ack) |=> !irq_tx_ready);
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_abort |-> (!tx_flag && irq_tx_ready));
endmodule

bind monitor_link monitor_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .rx_ack(rx_ack), .rx_flag(rx_flag),
  .rx_full(rx_full), .tx_ack(tx_ack), .tx_flag(tx_flag),
  .irq_rx_ready(irq_rx_ready), .irq_rx_abort(irq_rx_abort), .irq_eom(irq_eom),
  .irq_tx_ready(irq_tx_ready), .irq_tx_abort(irq_tx_abort)
);

// File: tb/tb_monitor_link.sv
module tb_monitor_link;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] fcnt;
  logic frame_tick;
  always_ff @(posedge clk) fcnt <= !rst_n ? 3'd0 : fcnt + 3'd1;
  assign frame_tick = fcnt == 3'd7;

  logic [7:0] d_txb, p_txb, p_wdata, d_rdata, p_rdata, d_rxb;
  logic d_txf, d_txa, p_txf, p_txa;
  logic d_rxr, d_rxab, d_eom, d_txr, d_txab;
  logic p_rxr, p_rxab, p_eom, p_txr, p_txab;
  logic p_wr = 0, p_last = 0, mon_rd = 0, task_rd = 0, corrupt = 0, auto_rd = 1;

  assign d_rxb = p_txb ^ (corrupt ? 8'h01 : 8'h00);

  monitor_link dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .rx_byte(d_rxb), .rx_flag(p_txf), .rx_ack(p_txa),
    .tx_byte(d_txb), .tx_flag(d_txf), .tx_ack(d_txa),
    .host_rd(mon_rd | task_rd), .rd_data(d_rdata),
    .host_wr(1'b0), .host_last(1'b0), .wr_data(8'h00),
    .irq_rx_ready(d_rxr), .irq_rx_abort(d_rxab), .irq_eom(d_eom),
    .irq_tx_ready(d_txr), .irq_tx_abort(d_txab));

  monitor_link peer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .rx_byte(d_txb), .rx_flag(d_txf), .rx_ack(d_txa),
    .tx_byte(p_txb), .tx_flag(p_txf), .tx_ack(p_txa),
    .host_rd(1'b0), .rd_data(p_rdata),
    .host_wr(p_wr), .host_last(p_last), .wr_data(p_wdata),
    .irq_rx_ready(p_rxr), .irq_rx_abort(p_rxab), .irq_eom(p_eom),
    .irq_tx_ready(p_txr), .irq_tx_abort(p_txab));

  int total = 0, fails = 0;
  int n_pop = 0, n_eom = 0, n_rxab = 0, n_txab = 0, n_ack = 0;
  logic [7:0] exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mon_rd <= 1'b0;
    if (rst_n) begin
      if (d_txa) n_ack++;
      if (d_eom) n_eom++;
      if (d_rxab) n_rxab++;
      if (p_txab) n_txab++;
      if (d_rxr) begin
        n_pop++;
        if (exp_q.size() == 0) chk("R1 R2 unexpected byte", {24'h0, d_rdata}, 32'hFFFF);
        else chk("R1 R2 scoreboard byte", {24'h0, d_rdata}, {24'h0, exp_q.pop_front()});
        if (auto_rd) mon_rd <= 1'b1;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!frame_tick);
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic send(logic [7:0] b, logic last, logic push);
    while (!p_txr) @(negedge clk);
    p_wr = 1; p_wdata = b; p_last = last;
    if (push) exp_q.push_back(b);
    @(negedge clk);
    p_wr = 0; p_last = 0;
    chk("R8 ready drops after write", {31'h0, p_txr}, 0);
  endtask

  initial begin
    int a0, e0, r0, t0, p0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset tx_flag", {31'h0, d_txf}, 0);
    chk("R3 reset tx_ack", {31'h0, d_txa}, 0);
    chk("R8 reset tx_ready", {31'h0, p_txr}, 1);
    chk("R1 reset rx_ready", {31'h0, d_rxr}, 0);

    // R2: equal consecutive bytes, explicit last byte
    a0 = n_ack; e0 = n_eom;
    send(8'h5A, 0, 1);
    wait_tick(); @(negedge clk);
    chk("R7 byte on line", {23'h0, p_txf, p_txb}, {23'h0, 1'b1, 8'h5A});
    send(8'h5A, 0, 1);
    send(8'h00, 1, 1);
    frames(14);
    chk("R2 all popped", exp_q.size(), 0);
    chk("R3 ack one frame per byte", n_ack - a0, 24);
    chk("R6 R9 eom after last", n_eom - e0, 1);

    // R9: single byte without last mark, nothing waiting
    e0 = n_eom;
    send(8'h7E, 0, 1);
    frames(8);
    chk("R9 eom when nothing waiting", n_eom - e0, 1);

    // R4 R10: corrupted second copy
    a0 = n_ack; e0 = n_eom; r0 = n_rxab; t0 = n_txab; p0 = n_pop;
    send(8'h33, 1, 0);
    while (!p_txf) @(negedge clk);
    wait_tick(); @(negedge clk);
    corrupt = 1;
    wait_tick(); @(negedge clk);
    corrupt = 0;
    frames(8);
    chk("R4 rx abort", n_rxab - r0, 1);
    chk("R4 two ack frames", n_ack - a0, 16);
    chk("R4 no delivery", n_pop - p0, 0);
    chk("R4 no eom", n_eom - e0, 0);
    chk("R10 tx abort", n_txab - t0, 1);
    chk("R10 idle after abort", {30'h0, p_txf, p_txr}, {30'h0, 1'b0, 1'b1});
    send(8'h33, 0, 1);
    send(8'h44, 1, 1);
    frames(12);
    chk("R10 resend delivered", exp_q.size(), 0);

    // R5: slow host, read coinciding with tick
    auto_rd = 0;
    e0 = n_eom;
    task_rd = 1; @(negedge clk); task_rd = 0;
    p0 = n_pop;
    send(8'h11, 0, 1);
    send(8'h22, 1, 1);
    while (n_pop == p0) @(negedge clk);
    frames(2);
    a0 = n_ack;
    frames(6);
    chk("R5 no ack while full", n_ack - a0, 0);
    chk("R5 sender still holding", {23'h0, p_txf, p_txb}, {23'h0, 1'b1, 8'h22});
    chk("R5 not delivered yet", n_pop - p0, 1);
    wait_tick();
    task_rd = 1;
    @(negedge clk);
    task_rd = 0;
    chk("R5 delivered at read tick", {30'h0, d_rxr, d_txa}, {30'h0, 1'b1, 1'b1});
    chk("R5 data", {24'h0, d_rdata}, 32'h22);
    frames(6);
    task_rd = 1; @(negedge clk); task_rd = 0;
    auto_rd = 1;
    chk("R6 eom after slow message", n_eom - e0, 1);
    chk("R2 queue empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule